// File: doc/BRIEF.md
# Complementary PWM Dead-Time Inserter

This block turns a raw pulse-width reference into a top/bottom switch-drive pair for each of several half-bridge channels. When a channel is set to complementary operation, only its top reference matters. The block derives the bottom drive as the inverse of that reference. At every transition of the reference, the output that is about to turn on is held off for a programmable number of system clock cycles, so the two switches of a pair are never on together. When a channel is set to independent operation, its two references are passed to the outputs unchanged.

The dead-time length is an 8-bit count of system clock cycles. It has no connection to any PWM period prescaler. The count is held in a configuration register on a simple write port. That register resets to all ones and accepts only the first write to its address after reset. Every later write is ignored until the next reset. A readable lock flag shows whether that first write has happened.

Top module: `dt_pair_gen`

## Requirements
- R1: While reset is asserted, all drive outputs are 0, `dt_value` reads 0xFF and `dt_locked` reads 0.
- R2: A write strobe with `wr_addr` equal to the dead-time address (default 6), issued while unlocked, loads `wr_data` into `dt_value` and sets `dt_locked` on the same clock edge.
- R3: Once `dt_locked` is 1, further writes leave `dt_value` and `dt_locked` unchanged until reset. A write to any other address neither loads the value nor sets the lock.
- R4: In complementary mode with dead-time D>0, a rising reference sampled at edge E clears the bottom output at edge E, keeps the top output low through edge E+D-1, and sets the top output at edge E+D.
- R5: In complementary mode with D>0, a falling reference sampled at edge E clears the top output at edge E, keeps the bottom output low through edge E+D-1, and sets the bottom output at edge E+D.
- R6: With D=0, complementary outputs follow the reference at the same edge it is sampled: top equals the reference and bottom equals its inverse.
- R7: A reference transition sampled while a dead-time is still counting restarts the count from D, and both outputs stay low until it expires.
- R8: In independent mode (`comp_en` bit 0), each output equals its own reference one clock after it is sampled.
- R9: In complementary mode, the top and bottom outputs of a pair are never 1 at the same time.
- R10: Switching a channel into complementary mode counts as a reference transition: both outputs go low and the reference's output turns on D edges later.
- R11: Each pair follows its own `comp_en` bit and references without affecting the other pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; dead-time counts its rising edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 4 | Configuration write address |
| wr_data | input | 8 | Configuration write data |
| comp_en | input | 3 | Per pair: 1 = complementary with dead-time, 0 = independent |
| ref_top | input | 3 | Per pair top reference; sole reference in complementary mode |
| ref_bot | input | 3 | Per pair bottom reference; used only in independent mode |
| pwm_top | output | 3 | Per pair top switch drive |
| pwm_bot | output | 3 | Per pair bottom switch drive |
| dt_value | output | 8 | Current dead-time count |
| dt_locked | output | 1 | 1 after the first accepted dead-time write |

## Verification
Every result is registered. A bus write shows on the readback at the first clock edge that samples it. An independent-mode reference, a zero-dead-time edge and the turn-off half of any transition show at that same first edge. The delayed turn-on comes D edges later. The driver numbers each stimulus by the edge that will sample it. It then queues the expected outputs for that edge, for the last dead edge and for the turn-on edge. The monitor compares each queued item only in the falling-clock half of the cycle it names, so outputs are never read while they change.

// File: rtl/dt_pkg.sv
package dt_pkg;

   // Per-channel phase of the dead-time sequencer.
   typedef enum logic [1:0] {
      PH_PASS  = 2'd0,  // independent operation, references forwarded
      PH_DEAD  = 2'd1,  // both switches held off while the count runs
      PH_DRIVE = 2'd2   // complementary drive settled
   } ch_phase_e;

endpackage

// File: rtl/dt_cfg_lock.sv
module dt_cfg_lock #(
   parameter int DT_W      = 8,
   parameter int ADDR_W    = 4,
   parameter int DT_ADDR   = 6,
   parameter logic [DT_W-1:0] RESET_VAL = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DT_W-1:0]   wr_data,
   output logic [DT_W-1:0]   dt_q,
   output logic              locked_q
);

   localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(DT_ADDR);

   logic hit;
   logic accept;

   assign hit    = wr_en && (wr_addr == SEL_ADDR);
   assign accept = hit && !locked_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dt_q     <= RESET_VAL;
         locked_q <= 1'b0;
      end else if (accept) begin
         dt_q     <= wr_data;
         locked_q <= 1'b1;
      end
   end

   // R2: the first write to the address loads the value and sets the lock
   a_r2_first_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == SEL_ADDR) && !locked_q) |=> (locked_q && (dt_q == $past(wr_data))));

   // R3: once locked, value and lock never move until reset
   a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q |=> (locked_q && $stable(dt_q)));

   // R3: writes elsewhere leave an unlocked register alone
   a_r3_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (!locked_q && !(wr_en && (wr_addr == SEL_ADDR))) |=> (!locked_q && $stable(dt_q)));

endmodule

// File: rtl/dt_channel.sv
module dt_channel
   import dt_pkg::*;
#(
   parameter int DT_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            comp_en,
   input  logic            ref_top,
   input  logic            ref_bot,
   input  logic [DT_W-1:0] dt_val,
   output logic            top_o,
   output logic            bot_o
);

   localparam logic [DT_W-1:0] CNT_ONE  = DT_W'(1);
   localparam logic [DT_W-1:0] CNT_ZERO = '0;

   ch_phase_e       phase_q, phase_n;
   logic [DT_W-1:0] cnt_q, cnt_n;
   logic            ref_q;
   logic            mode_q;
   logic            top_q, top_n;
   logic            bot_q, bot_n;
   logic            trig;

   // A new transition, or the first cycle in complementary mode.
   assign trig = !mode_q || (ref_top != ref_q);

   always_comb begin
      phase_n = phase_q;
      cnt_n   = cnt_q;
      top_n   = top_q;
      bot_n   = bot_q;
      if (!comp_en) begin
         phase_n = PH_PASS;
         cnt_n   = CNT_ZERO;
         top_n   = ref_top;
         bot_n   = ref_bot;
      end else if (trig) begin
         if (dt_val == CNT_ZERO) begin
            phase_n = PH_DRIVE;
            cnt_n   = CNT_ZERO;
            top_n   = ref_top;
            bot_n   = !ref_top;
         end else begin
            phase_n = PH_DEAD;
            cnt_n   = dt_val;
            top_n   = 1'b0;
            bot_n   = 1'b0;
         end
      end else if (phase_q == PH_DEAD) begin
         if (cnt_q == CNT_ONE) begin
            phase_n = PH_DRIVE;
            cnt_n   = CNT_ZERO;
            top_n   = ref_q;
            bot_n   = !ref_q;
         end else begin
            cnt_n = cnt_q - CNT_ONE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_PASS;
         cnt_q   <= CNT_ZERO;
         ref_q   <= 1'b0;
         mode_q  <= 1'b0;
         top_q   <= 1'b0;
         bot_q   <= 1'b0;
      end else begin
         phase_q <= phase_n;
         cnt_q   <= cnt_n;
         ref_q   <= ref_top;
         mode_q  <= comp_en;
         top_q   <= top_n;
         bot_q   <= bot_n;
      end
   end

   assign top_o = top_q;
   assign bot_o = bot_q;

   // R9: no shoot-through while complementary
   a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q |-> !(top_q && bot_q));

   // R7: both switches off for as long as the count runs
   a_r7_dead_off: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_DEAD) |-> (!top_q && !bot_q && (cnt_q != CNT_ZERO)));

   // R8: independent mode forwards each reference one clock later
   a_r8_pass: assert property (@(posedge clk) disable iff (!rst_n)
      !comp_en |=> ((top_q == $past(ref_top)) && (bot_q == $past(ref_bot))));

   // R4/R5: a transition with nonzero dead-time switches both outputs off
   a_r4_edge_off: assert property (@(posedge clk) disable iff (!rst_n)
      (comp_en && (ref_top != ref_q) && (dt_val != CNT_ZERO)) |=> (!top_q && !bot_q));

   // R6: zero dead-time gives complementary outputs at once
   a_r6_zero_dt: assert property (@(posedge clk) disable iff (!rst_n)
      (comp_en && trig && (dt_val == CNT_ZERO)) |=> ((top_q == $past(ref_top)) && (bot_q != top_q)));

endmodule

// File: rtl/dt_pair_gen.sv
module dt_pair_gen #(
   parameter int NUM_PAIRS = 3,
   parameter int DT_W      = 8,
   parameter int ADDR_W    = 4,
   parameter int DT_ADDR   = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [DT_W-1:0]      wr_data,
   input  logic [NUM_PAIRS-1:0] comp_en,
   input  logic [NUM_PAIRS-1:0] ref_top,
   input  logic [NUM_PAIRS-1:0] ref_bot,
   output logic [NUM_PAIRS-1:0] pwm_top,
   output logic [NUM_PAIRS-1:0] pwm_bot,
   output logic [DT_W-1:0]      dt_value,
   output logic                 dt_locked
);

   localparam int ADDR_SPAN = 1 << ADDR_W;

   generate
      if (NUM_PAIRS < 1) begin : g_chk_pairs
         $error("dt_pair_gen: NUM_PAIRS must be at least 1");
      end
      if (DT_W < 1 || DT_W > 16) begin : g_chk_width
         $error("dt_pair_gen: DT_W must be between 1 and 16");
      end
      if (DT_ADDR < 0 || DT_ADDR >= ADDR_SPAN) begin : g_chk_addr
         $error("dt_pair_gen: DT_ADDR does not fit in ADDR_W bits");
      end
   endgenerate

   logic [DT_W-1:0] dt_q;
   logic            locked_q;

   dt_cfg_lock #(
      .DT_W      (DT_W),
      .ADDR_W    (ADDR_W),
      .DT_ADDR   (DT_ADDR),
      .RESET_VAL ({DT_W{1'b1}})
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .dt_q     (dt_q),
      .locked_q (locked_q)
   );

   generate
      for (genvar gi = 0; gi < NUM_PAIRS; gi++) begin : g_pair
         dt_channel #(
            .DT_W (DT_W)
         ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .comp_en (comp_en[gi]),
            .ref_top (ref_top[gi]),
            .ref_bot (ref_bot[gi]),
            .dt_val  (dt_q),
            .top_o   (pwm_top[gi]),
            .bot_o   (pwm_bot[gi])
         );
      end
   endgenerate

   assign dt_value  = dt_q;
   assign dt_locked = locked_q;

   // R1: register reset value observed right after reset release
   a_r1_reset_val: assert property (@(posedge clk) disable iff (!rst_n)
      !locked_q |-> (dt_q == {DT_W{1'b1}}) || $past(wr_en));

endmodule

// File: tb/dt_pair_gen_bench.sv
module dt_pair_gen_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NP         = 3;
   localparam int WATCHDOG   = 20000;

   typedef struct {
      int          cyc;
      bit          is_reg;
      int          pair;
      logic        top;
      logic        bot;
      logic [7:0]  dt;
      logic        lk;
      string       tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          wr_en;
   logic [3:0]    wr_addr;
   logic [7:0]    wr_data;
   logic [NP-1:0] comp_en, ref_top, ref_bot;
   logic [NP-1:0] pwm_top, pwm_bot;
   logic [7:0]    dt_value;
   logic          dt_locked;

   int   cyc = 0;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 0;
   exp_t q[$];

   dt_pair_gen u_dt_pair_gen (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .comp_en(comp_en), .ref_top(ref_top),
      .ref_bot(ref_bot), .pwm_top(pwm_top), .pwm_bot(pwm_bot),
      .dt_value(dt_value), .dt_locked(dt_locked)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(string tag, int act, int expv);
      n_chk++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, expv, cyc);
      end
   endtask

   task automatic push_out(int c, int p, logic t, logic b, string tag);
      exp_t e;
      e.cyc = c; e.is_reg = 0; e.pair = p; e.top = t; e.bot = b;
      e.dt = '0; e.lk = 1'b0; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic push_reg(int c, logic [7:0] d, logic l, string tag);
      exp_t e;
      e.cyc = c; e.is_reg = 1; e.pair = 0; e.top = 1'b0; e.bot = 1'b0;
      e.dt = d; e.lk = l; e.tag = tag;
      q.push_back(e);
   endtask

   // monitor: compares items in the low half of the cycle they name
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].cyc <= cyc) begin
         exp_t e;
         e = q.pop_front();
         if (e.is_reg) begin
            chk({e.tag, " dt_value"}, int'(dt_value), int'(e.dt));
            chk({e.tag, " dt_locked"}, int'(dt_locked), int'(e.lk));
         end else begin
            chk($sformatf("%s pair%0d top/bot", e.tag, e.pair),
                int'({pwm_top[e.pair], pwm_bot[e.pair]}), int'({e.top, e.bot}));
         end
      end
   end

   task automatic tick(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic bus_write(logic [3:0] a, logic [7:0] d, logic [7:0] edt, logic elk, string tag);
      int c;
      c = cyc + 1;
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      push_reg(c, edt, elk, tag);
      tick(1);
      wr_en = 1'b0;
      tick(1);
   endtask

   // complementary transition on pair p with dead-time D>0
   task automatic comp_edge(int p, logic lvl, int D, string tag);
      int c;
      c = cyc + 1;
      ref_top[p] = lvl;
      push_out(c, p, 1'b0, 1'b0, tag);
      if (D > 1) push_out(c + D - 1, p, 1'b0, 1'b0, tag);
      push_out(c + D, p, lvl, !lvl, tag);
      tick(D + 1);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick(2);
      chk("R1 pwm_top", int'(pwm_top), 0);
      chk("R1 pwm_bot", int'(pwm_bot), 0);
      chk("R1 dt_value", int'(dt_value), 'hFF);
      chk("R1 dt_locked", int'(dt_locked), 0);
      rst_n = 1'b1;
      tick(1);
   endtask

   initial begin
      int c;
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      comp_en = '0; ref_top = '0; ref_bot = '0;
      tick(1);
      do_reset();

      // R8: independent pass-through on pair 0
      c = cyc + 1;
      ref_top[0] = 1'b1; ref_bot[0] = 1'b1;
      push_out(c, 0, 1'b1, 1'b1, "R8");
      tick(2);

      // R3: wrong address neither loads nor locks; R2: first write loads
      bus_write(4'd5, 8'd3, 8'hFF, 1'b0, "R3 other address");
      bus_write(4'd6, 8'd3, 8'd3, 1'b1, "R2 first write");
      bus_write(4'd6, 8'd9, 8'd3, 1'b1, "R3 second write");

      // R10: enter complementary with reference low
      ref_top[0] = 1'b0; ref_bot[0] = 1'b0; tick(1);
      c = cyc + 1;
      comp_en[0] = 1'b1;
      push_out(c, 0, 1'b0, 1'b0, "R10");
      push_out(c + 2, 0, 1'b0, 1'b0, "R10");
      push_out(c + 3, 0, 1'b0, 1'b1, "R10");
      tick(4);

      comp_edge(0, 1'b1, 3, "R4 rise");
      comp_edge(0, 1'b0, 3, "R5 fall");

      // R7: retrigger mid-count; R11: pair 1 independent meanwhile
      c = cyc + 1;
      ref_top[0] = 1'b1;
      ref_top[1] = 1'b1; ref_bot[1] = 1'b1;
      push_out(c, 0, 1'b0, 1'b0, "R7");
      push_out(c, 1, 1'b1, 1'b1, "R11");
      push_out(c + 1, 0, 1'b0, 1'b0, "R7");
      push_out(c + 3, 0, 1'b0, 1'b0, "R7");
      push_out(c + 4, 0, 1'b0, 1'b1, "R7");
      tick(1);
      ref_top[0] = 1'b0;
      tick(5);

      // R8: back to independent with differing references
      c = cyc + 1;
      comp_en[0] = 1'b0; ref_top[0] = 1'b1; ref_bot[0] = 1'b0;
      push_out(c, 0, 1'b1, 1'b0, "R8 leave comp");
      tick(2);

      // second run with zero dead-time
      comp_en = '0; ref_top = '0; ref_bot = '0;
      do_reset();
      bus_write(4'd6, 8'd0, 8'd0, 1'b1, "R2 zero write");
      c = cyc + 1;
      comp_en[2] = 1'b1;
      push_out(c, 2, 1'b0, 1'b1, "R6 enter");
      tick(2);
      c = cyc + 1;
      ref_top[2] = 1'b1;
      push_out(c, 2, 1'b1, 1'b0, "R6 rise");
      tick(2);
      c = cyc + 1;
      ref_top[2] = 1'b0;
      push_out(c, 2, 1'b0, 1'b1, "R6 fall");
      tick(3);

      if (q.size() != 0) begin
         n_chk++; n_fail++;
         $display("FAIL scoreboard: actual %0d items left expected 0", q.size());
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   always @(posedge clk) begin
      if (!done && cyc > WATCHDOG) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WATCHDOG);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule